// File: doc/BRIEF.md
# External Bus Chip-Enable and Wait-State Controller

This block is the system-control register group of a small 8-bit microcontroller. Software writes three byte-wide registers. The bus-control register picks the bus mode, the size of each chip-enable region and which of the four chip-enable pins act as selects. The stack-page register supplies the page for stack addressing. The wait/clock register holds the wait-state code and a few clock and power bits that are only stored.

From these registers the block derives three things for each CPU bus cycle. It drives the four chip-enable pins. It stretches external accesses by an even number of stall cycles through the `bus_ready` signal. It forwards the maskable and non-maskable interrupt requests only once software has set up both the bus-control register and the stack-page register after reset.

The stall sequencer is a two-state machine:
- `ST_IDLE` is the resting state. It takes the transition *stall-start* to `ST_STALL` when an external access begins with a non-zero wait code, and loads the down-counter at that point.
- `ST_STALL` counts down. It takes the transition *count-expired* back to `ST_IDLE` when the counter reaches zero, and raises `bus_ready` in that cycle.
- An access that starts with a zero wait code stays in `ST_IDLE` and completes in its first cycle.

Top module: `sysctl_bus_wait`

## Requirements
- R1: After reset, the bus-control register (address 0), the stack-page register (address 1) and the wait/clock register (address 2) all read 0. `sp_page` is 0, and both interrupt outputs are 0.
- R2: A write with `reg_we` high stores `reg_wdata` at `reg_addr` 0, 1 or 2, and `reg_rdata` returns the stored value. Address 3 reads 0, and writes to it change nothing. Bus-control layout: bits 1:0 hold the bus mode, bits 3:2 the region size, and bit 4+n is the enable for pin n. Wait/clock layout: bits 2:0 hold the wait code, bit 3 the CPU clock select, bit 4 the oscillator-on bit, bits 6:5 the operating mode, and bit 7 the bus-release enable.
- R3: `irq_out` and `nmi_out` stay 0 until both address 0 and address 1 have been written since reset, in either order. Writes to address 2 do not count. From then on each output equals its request input.
- R4: Region size codes are 11 = 64K (only `ce_o[0]` used), 10 = 32K (pins 0 and 1), 01 = 16K and 00 = 8K (all four pins). Regions are stacked from address 0 in pin order. An enabled pin outputs 1 only during an external access whose address falls in its region.
- R5: A pin whose enable bit is 0 outputs the matching bit of `port_dout`.
- R6: Bus mode 00 (single-chip) makes every pin output its `port_dout` bit, whatever the enable bits hold. In this mode no access is external, and no stall is added.
- R7: An external access with wait code k (0 to 7) holds `bus_ready` low for exactly 2k cycles. `bus_ready` is high in the cycle that completes the access.
- R8: An access to the internal block (address bits above bit 11 equal to `INT_PAGE`, default 0x0F000 to 0x0FFFF) gets no stall and asserts no chip enable.
- R9: In single-chip mode `sp_page` is 0 whatever the stack-page register holds. In the other bus modes `sp_page` equals that register.
- R10: An external access above the last region in use (for example at 0x10000 or higher with size code 11) asserts no chip enable, but it still receives the wait states.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register index |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data (combinational) |
| bus_valid | input | 1 | CPU bus cycle in progress, held until completion |
| bus_addr | input | ADDR_W (19) | CPU bus-cycle address |
| bus_ready | output | 1 | High when the current access completes at the next edge |
| port_dout | input | 4 | Values for pins used as plain outputs |
| ce_o | output | 4 | Chip-enable / output-port pins, active high |
| irq_req | input | NIRQ (8) | Raw maskable interrupt requests |
| nmi_req | input | 1 | Raw non-maskable request |
| irq_out | output | NIRQ (8) | Gated maskable requests |
| nmi_out | output | 1 | Gated non-maskable request |
| sp_page | output | 8 | Effective stack page |

## Verification
The assertions assume the CPU holds `bus_valid` and `bus_addr` steady from the start of an access until the edge at which `bus_ready` is high. They also assume no new access starts while the sequencer is in `ST_STALL`. The bench drives each access as one task that changes the address only at a negative edge. That task drops or replaces the request only after it has seen `bus_ready` high. Random register settings and addresses come from a seeded `$urandom`, with internal-block addresses mixed in on purpose. The expected pin values and stall counts are computed by bench functions written from R4 to R10.

// File: rtl/sysctl_pkg.sv
package sysctl_pkg;

    typedef enum logic {
        ST_IDLE  = 1'b0,
        ST_STALL = 1'b1
    } stall_st_t;

    typedef struct packed {
        logic [3:0] ce_en;
        logic [1:0] ce_size;
        logic [1:0] bus_mode;
    } busctl_t;

    typedef struct packed {
        logic       bus_rel_en;
        logic [1:0] op_mode;
        logic       osc_on;
        logic       clk_sel;
        logic [2:0] wait_code;
    } waitctl_t;

    localparam logic [1:0] MODE_SINGLE = 2'b00;
    localparam logic [1:0] IDX_BUS     = 2'd0;
    localparam logic [1:0] IDX_STACK   = 2'd1;
    localparam logic [1:0] IDX_WAIT    = 2'd2;

endpackage

// File: rtl/sysctl_regs.sv
module sysctl_regs
    import sysctl_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       reg_we,
    input  logic [1:0] reg_addr,
    input  logic [7:0] reg_wdata,
    output logic [7:0] reg_rdata,
    output busctl_t    busctl,
    output waitctl_t   waitctl,
    output logic [7:0] stack_raw,
    output logic       armed
);
    logic seen_bus_q;
    logic seen_stack_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            busctl       <= '0;
            waitctl      <= '0;
            stack_raw    <= '0;
            seen_bus_q   <= 1'b0;
            seen_stack_q <= 1'b0;
        end else if (reg_we) begin
            unique case (reg_addr)
                IDX_BUS: begin
                    busctl     <= busctl_t'(reg_wdata);
                    seen_bus_q <= 1'b1;
                end
                IDX_STACK: begin
                    stack_raw    <= reg_wdata;
                    seen_stack_q <= 1'b1;
                end
                IDX_WAIT: waitctl <= waitctl_t'(reg_wdata);
                default: ;
            endcase
        end
    end

    always_comb begin
        unique case (reg_addr)
            IDX_BUS:   reg_rdata = busctl;
            IDX_STACK: reg_rdata = stack_raw;
            IDX_WAIT:  reg_rdata = waitctl;
            default:   reg_rdata = 8'h00;
        endcase
    end

    assign armed = seen_bus_q & seen_stack_q;

    // R3
    armed_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        armed |=> armed);

    // R2
    stack_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_we && reg_addr == IDX_STACK) |=> (stack_raw == $past(reg_wdata)));

endmodule

// File: rtl/sysctl_cedec.sv
module sysctl_cedec #(
    parameter int ADDR_W = 19,
    parameter int NCE    = 4,
    parameter int MIN_SH = 13
) (
    input  logic              acc_ext,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [1:0]        ce_size,
    output logic [NCE-1:0]    ce_sel
);
    logic [ADDR_W-1:0] region;
    logic [2:0]        used;

    always_comb begin
        region = bus_addr >> (MIN_SH + int'(ce_size));
        unique case (ce_size)
            2'b11:   used = 3'd1;
            2'b10:   used = 3'd2;
            default: used = 3'd4;
        endcase
    end

    for (genvar n = 0; n < NCE; n++) begin : g_sel
        assign ce_sel[n] = acc_ext && (n < int'(used)) && (region == ADDR_W'(n));
    end

endmodule

// File: rtl/sysctl_stall.sv
module sysctl_stall
    import sysctl_pkg::*;
#(
    parameter int WAIT_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              acc_ext,
    input  logic [WAIT_W-1:0] wait_code,
    output logic              ready
);
    localparam int CNT_W = WAIT_W + 1;

    stall_st_t        st_q, st_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q  <= ST_IDLE;
            cnt_q <= '0;
        end else begin
            st_q  <= st_d;
            cnt_q <= cnt_d;
        end
    end

    always_comb begin
        st_d  = st_q;
        cnt_d = cnt_q;
        unique case (st_q)
            ST_IDLE:
                if (acc_ext && wait_code != '0) begin
                    st_d  = ST_STALL;
                    cnt_d = {wait_code, 1'b0} - CNT_W'(1);
                end
            ST_STALL:
                if (cnt_q == '0) st_d  = ST_IDLE;
                else             cnt_d = cnt_q - CNT_W'(1);
        endcase
    end

    always_comb begin
        unique case (st_q)
            ST_IDLE:  ready = !(acc_ext && wait_code != '0);
            ST_STALL: ready = (cnt_q == '0);
        endcase
    end

    // R7
    stall_countdown_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_STALL && cnt_q != '0) |=>
            (st_q == ST_STALL && cnt_q == CNT_W'($past(cnt_q) - CNT_W'(1))));

    // R7
    stall_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_STALL && cnt_q == '0) |=> (st_q == ST_IDLE));

endmodule

// File: rtl/sysctl_bus_wait.sv
module sysctl_bus_wait
    import sysctl_pkg::*;
#(
    parameter int ADDR_W    = 19,
    parameter int NIRQ      = 8,
    parameter int INT_BLK_W = 12,
    parameter int INT_PAGE  = 15
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_we,
    input  logic [1:0]        reg_addr,
    input  logic [7:0]        reg_wdata,
    output logic [7:0]        reg_rdata,
    input  logic              bus_valid,
    input  logic [ADDR_W-1:0] bus_addr,
    output logic              bus_ready,
    input  logic [3:0]        port_dout,
    output logic [3:0]        ce_o,
    input  logic [NIRQ-1:0]   irq_req,
    input  logic              nmi_req,
    output logic [NIRQ-1:0]   irq_out,
    output logic              nmi_out,
    output logic [7:0]        sp_page
);
    localparam int NCE  = 4;
    localparam int HI_W = ADDR_W - INT_BLK_W;

    busctl_t    busctl;
    waitctl_t   waitctl;
    logic [7:0] stack_raw;
    logic       armed;
    logic       single;
    logic       is_int;
    logic       acc_ext;
    logic [NCE-1:0] ce_sel;

    sysctl_regs u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .reg_we   (reg_we),
        .reg_addr (reg_addr),
        .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata),
        .busctl   (busctl),
        .waitctl  (waitctl),
        .stack_raw(stack_raw),
        .armed    (armed)
    );

    assign single  = (busctl.bus_mode == MODE_SINGLE);
    assign is_int  = (bus_addr[ADDR_W-1:INT_BLK_W] == HI_W'(INT_PAGE));
    assign acc_ext = bus_valid && !single && !is_int;

    sysctl_cedec #(.ADDR_W(ADDR_W), .NCE(NCE), .MIN_SH(13)) u_cedec (
        .acc_ext (acc_ext),
        .bus_addr(bus_addr),
        .ce_size (busctl.ce_size),
        .ce_sel  (ce_sel)
    );

    sysctl_stall #(.WAIT_W(3)) u_stall (
        .clk      (clk),
        .rst_n    (rst_n),
        .acc_ext  (acc_ext),
        .wait_code(waitctl.wait_code),
        .ready    (bus_ready)
    );

    for (genvar n = 0; n < NCE; n++) begin : g_pin
        assign ce_o[n] = (busctl.ce_en[n] && !single) ? ce_sel[n] : port_dout[n];
    end

    assign irq_out = irq_req & {NIRQ{armed}};
    assign nmi_out = nmi_req & armed;
    assign sp_page = single ? 8'h00 : stack_raw;

    // R4
    ce_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(ce_sel));

    // R8
    int_no_select_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_valid && is_int) |-> (ce_sel == '0));

    // R8
    int_no_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_valid && is_int) |-> bus_ready);

    // R6
    single_no_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_valid && single) |-> (bus_ready && ce_sel == '0));

endmodule

// File: tb/tb_sysctl_bus_wait.sv
module tb_sysctl_bus_wait;
    localparam int CLK_PERIOD = 10;
    localparam int AW = 19;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          reg_we = 1'b0;
    logic [1:0]    reg_addr = '0;
    logic [7:0]    reg_wdata = '0;
    logic [7:0]    reg_rdata;
    logic          bus_valid = 1'b0;
    logic [AW-1:0] bus_addr = '0;
    logic          bus_ready;
    logic [3:0]    port_dout = '0;
    logic [3:0]    ce_o;
    logic [7:0]    irq_req = '0;
    logic          nmi_req = 1'b0;
    logic [7:0]    irq_out;
    logic          nmi_out;
    logic [7:0]    sp_page;

    int n_chk = 0;
    int n_bad = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    sysctl_bus_wait dut (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .bus_valid(bus_valid),
        .bus_addr(bus_addr), .bus_ready(bus_ready), .port_dout(port_dout),
        .ce_o(ce_o), .irq_req(irq_req), .nmi_req(nmi_req), .irq_out(irq_out),
        .nmi_out(nmi_out), .sp_page(sp_page)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_addr = a; reg_wdata = d; reg_we = 1'b1;
        @(negedge clk);
        reg_we = 1'b0;
        #1;
    endtask

    task automatic rd(input logic [1:0] a, output logic [7:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    // one bus access; reports pins seen in its first cycle and stall count
    task automatic access(input logic [AW-1:0] a, output logic [3:0] ce, output int stalls);
        @(negedge clk);
        bus_addr = a; bus_valid = 1'b1;
        #1;
        ce = ce_o;
        stalls = 0;
        while (!bus_ready && stalls < 40) begin
            stalls++;
            @(negedge clk);
            #1;
        end
        @(negedge clk);
        bus_valid = 1'b0;
    endtask

    function automatic logic [3:0] exp_pins(input logic [AW-1:0] a, input logic [7:0] bc,
                                            input logic [3:0] pd);
        logic [3:0] r;
        int kb   = 8 << bc[3:2];
        int reg_i = int'(a) / (kb * 1024);
        int used = (bc[3:2] == 2'b11) ? 1 : (bc[3:2] == 2'b10) ? 2 : 4;
        logic internal = ((int'(a) >> 12) == 15);
        for (int i = 0; i < 4; i++) begin
            if (bc[1:0] == 2'b00 || !bc[4+i]) r[i] = pd[i];
            else r[i] = !internal && (reg_i == i) && (i < used);
        end
        return r;
    endfunction

    function automatic int exp_stalls(input logic [AW-1:0] a, input logic [7:0] bc,
                                      input logic [7:0] wc);
        logic internal = ((int'(a) >> 12) == 15);
        if (bc[1:0] == 2'b00 || internal) return 0;
        return 2 * int'(wc[2:0]);
    endfunction

    initial begin
        #(CLK_PERIOD * 200000);
        n_chk++; n_bad++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        logic [7:0] d;
        logic [3:0] ce;
        int st;
        logic [7:0] bc, wc;
        logic [AW-1:0] a;
        void'($urandom(32'd1357));

        do_reset();
        #1;
        // R1 reset state
        rd(2'd0, d); check("R1 busctl", d, 8'h00);
        rd(2'd1, d); check("R1 stack", d, 8'h00);
        rd(2'd2, d); check("R1 waitctl", d, 8'h00);
        irq_req = 8'hA5; nmi_req = 1'b1; #1;
        check("R1 irq", {irq_out, 7'd0, nmi_out}, 32'd0);
        check("R1 sp_page", sp_page, 8'h00);

        // R3 order bus then stack, wait register does not count
        wr(2'd2, 8'h07);
        check("R3 after wait reg", {irq_out, 7'd0, nmi_out}, 32'd0);
        wr(2'd0, 8'h00);
        check("R3 after bus reg", {irq_out, 7'd0, nmi_out}, 32'd0);
        wr(2'd1, 8'h27);
        check("R3 armed irq", irq_out, 8'hA5);
        check("R3 armed nmi", nmi_out, 1'b1);
        irq_req = 8'h3C; nmi_req = 1'b0; #1;
        check("R3 follows", {irq_out, 7'd0, nmi_out}, {8'h3C, 7'd0, 1'b0});

        // R9 single-chip forces page 0
        check("R9 single sp", sp_page, 8'h00);
        rd(2'd1, d); check("R2 stack readback", d, 8'h27);
        wr(2'd0, 8'h01);
        check("R9 64K sp", sp_page, 8'h27);

        // R2 address 3 and misc bits
        wr(2'd3, 8'hFF);
        rd(2'd3, d); check("R2 addr3 reads 0", d, 8'h00);
        rd(2'd0, d); check("R2 addr3 no effect bus", d, 8'h01);
        rd(2'd1, d); check("R2 addr3 no effect stack", d, 8'h27);
        rd(2'd2, d); check("R2 addr3 no effect wait", d, 8'h07);
        wr(2'd2, 8'hF8);
        rd(2'd2, d); check("R2 misc bits", d, 8'hF8);

        // R3 other order after a fresh reset
        do_reset();
        irq_req = 8'hFF; nmi_req = 1'b1;
        wr(2'd1, 8'h05);
        check("R3 stack only", {irq_out, 7'd0, nmi_out}, 32'd0);
        wr(2'd0, 8'h00);
        check("R3 stack then bus", {irq_out, 7'd0, nmi_out}, {8'hFF, 7'd0, 1'b1});

        // R6 single-chip: pins are port outputs, no stall
        port_dout = 4'b0110;
        wr(2'd0, 8'hF0); wr(2'd2, 8'h07);
        access(19'h00100, ce, st);
        check("R6 pins", ce, 4'b0110);
        check("R6 stalls", st, 0);

        // R7 every wait code, 64K mode, 64K regions
        wr(2'd0, 8'hFD);
        for (int k = 0; k < 8; k++) begin
            wr(2'd2, 8'(k));
            access(19'h00100, ce, st);
            check("R7 stalls", st, 2 * k);
            check("R4 CE0 select", ce, 4'b0001);
        end

        // R8 internal block
        wr(2'd2, 8'h07);
        access(19'h0F010, ce, st);
        check("R8 internal pins", ce, 4'b0000);
        check("R8 internal stalls", st, 0);

        // R10 beyond last used region
        access(19'h10000, ce, st);
        check("R10 pins", ce, 4'b0000);
        check("R10 stalls", st, 14);

        // R4 8K regions: 0x06000 is region 3
        wr(2'd0, 8'hF1); wr(2'd2, 8'h00);
        access(19'h06000, ce, st);
        check("R4 8K CE3", ce, 4'b1000);

        // R5 disabled pins show port values
        port_dout = 4'b1010;
        wr(2'd0, 8'h51);
        access(19'h02000, ce, st);
        check("R5 mixed pins", ce, 4'b1010);
        access(19'h00000, ce, st);
        check("R5 CE0 enabled", ce, 4'b1011);

        // random sweep
        for (int it = 0; it < 400; it++) begin
            bc = 8'($urandom);
            wc = 8'($urandom);
            port_dout = 4'($urandom);
            if (($urandom % 4) == 0) a = AW'(32'h0F000 + ($urandom % 4096));
            else a = AW'($urandom);
            wr(2'd0, bc);
            wr(2'd2, wc);
            access(a, ce, st);
            check("R4/R5/R6 random pins", ce, exp_pins(a, bc, port_dout));
            check("R7/R8 random stalls", st, exp_stalls(a, bc, wc));
            check("R9 random sp", sp_page, (bc[1:0] == 2'b00) ? 8'h00 : 8'h05);
        end

        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

endmodule